// File: doc/BRIEF.md
# CAN Fault Confinement Error Counters

This block holds the two fault-confinement counters of a CAN node, one for receive errors (8 bits) and one for transmit errors (9 bits), and derives from them the node's error state. The protocol engine drives it with one-cycle event strobes. The strobes report:

- receiver-detected errors, with qualifiers for bit errors seen while the node drives an active error flag or an overload flag;
- a dominant first bit after an error flag;
- transmitter error flags, with qualifiers for the two penalty exemptions;
- transmitter bit errors during its own flags;
- penalty pulses from a dominant-sequence monitor, together with a role input that names the node as transmitter or receiver;
- successful reception and successful transmission.

The counters are registered. The error-active, error-passive and bus-off flags are decoded from the registered values, so any event is visible on the outputs one clock after its strobe. Once the node reaches bus-off, the transmit counter freezes. Only the synchronous clear input brings both counters back to zero, and the surrounding logic decides when to apply it.

Top module: `can_fault_conf`

## Requirements
- R1: After reset both counters read 0 and only errorActive is high.
- R2: A rxErr strobe adds 1 to the receive count. With rxBitErrAct it adds 8 instead. With rxBitErrOvl (and no rxBitErrAct) it leaves the count unchanged.
- R3: The receive count gains 8 for rxDomAfterFlag and another 8 for domPenalty with isTx=0. Simultaneous receive increments are summed.
- R4: The receive count saturates at 255 and never wraps.
- R5: On rxOk the receive count stays 0 if it is 0, drops by 1 if it is 1 to 127, and is reloaded to 119 if it is above 127.
- R6: txErrFlag adds 8 to the transmit count unless txAckPassNoDom or txArbStuff is high. txBitErrFlag adds 8. domPenalty with isTx=1 adds 8. These increments are summed.
- R7: txOk lowers the transmit count by 1 unless it is 0.
- R8: A success decrement of a counter is dropped when an increment of the same counter occurs in the same cycle.
- R9: busOff is high when the transmit count exceeds 255. Otherwise errorPassive is high when either count exceeds 127. Otherwise errorActive is high. Exactly one flag is high at a time.
- R10: While busOff is high, the transmit count holds its value and ignores all transmit events.
- R11: A clear strobe sets both counters to 0 on the next edge, overriding every other event in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of both counters |
| rxErr | input | 1 | Receiver detected an error |
| rxBitErrAct | input | 1 | Qualifier: the rxErr is a bit error while sending an active error flag |
| rxBitErrOvl | input | 1 | Qualifier: the rxErr is a bit error while sending an overload flag |
| rxDomAfterFlag | input | 1 | First bit after the node's error flag was dominant |
| txErrFlag | input | 1 | Transmitter sends an error flag |
| txAckPassNoDom | input | 1 | Exemption: passive ack error with no dominant bit during the passive flag |
| txArbStuff | input | 1 | Exemption: stuff error in arbitration on a recessive bit read back dominant |
| txBitErrFlag | input | 1 | Transmitter bit error while sending an active error flag or overload flag |
| domPenalty | input | 1 | Penalty pulse from the dominant-sequence monitor |
| isTx | input | 1 | Node role: 1 for transmitter, 0 for receiver |
| rxOk | input | 1 | Successful reception |
| txOk | input | 1 | Successful transmission |
| rec | output | 8 | Receive error count |
| tec | output | 9 | Transmit error count |
| errorActive | output | 1 | Node is error-active |
| errorPassive | output | 1 | Node is error-passive |
| busOff | output | 1 | Node is bus-off |

## Verification
Two situations are hardest to reach from the ports: the receive count sitting above 127 when a good reception arrives, and the transmit count crossing 255 into bus-off. Both need long runs in which increments outnumber decrements. The directed part of the bench pushes the receive count into saturation with penalty bursts before applying rxOk. It also pushes the transmit count past 255 with error flags and then offers every transmit event to show the freeze. The random part runs phases whose probabilities favour one counter, so both boundaries are crossed repeatedly with mixed, simultaneous events, and occasional clears leave bus-off again.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  localparam int MAJOR_INC = 8;
  localparam int MINOR_INC = 1;
  localparam int ADD_W     = 5;

  typedef struct packed {
    logic rxErr;
    logic rxBitErrAct;
    logic rxBitErrOvl;
    logic rxDomAfterFlag;
    logic txErrFlag;
    logic txAckPassNoDom;
    logic txArbStuff;
    logic txBitErrFlag;
    logic domPenalty;
    logic isTx;
    logic rxOk;
    logic txOk;
    logic clr;
  } evt_t;

  typedef struct packed {
    logic [ADD_W-1:0] recAdd;
    logic             recDec;
    logic [ADD_W-1:0] tecAdd;
    logic             tecDec;
    logic             clr;
  } strb_t;
endpackage

// File: rtl/can_fc_ctrl.sv
module can_fc_ctrl
  import can_fc_pkg::*;
(
  input  evt_t  evt,
  input  logic  busOff,
  output strb_t strb
);
  localparam logic [ADD_W-1:0] BIG   = ADD_W'(MAJOR_INC);
  localparam logic [ADD_W-1:0] SMALL = ADD_W'(MINOR_INC);

  logic [ADD_W-1:0] recAddC;
  logic [ADD_W-1:0] tecAddC;

  always_comb begin
    recAddC = '0;
    if (evt.rxErr) begin
      if (evt.rxBitErrAct)       recAddC = recAddC + BIG;
      else if (!evt.rxBitErrOvl) recAddC = recAddC + SMALL;
    end
    if (evt.rxDomAfterFlag)            recAddC = recAddC + BIG;
    if (evt.domPenalty && !evt.isTx)   recAddC = recAddC + BIG;
  end

  always_comb begin
    tecAddC = '0;
    if (evt.txErrFlag && !evt.txAckPassNoDom && !evt.txArbStuff)
      tecAddC = tecAddC + BIG;
    if (evt.txBitErrFlag)              tecAddC = tecAddC + BIG;
    if (evt.domPenalty && evt.isTx)    tecAddC = tecAddC + BIG;
    if (busOff)                        tecAddC = '0;
  end

  always_comb begin
    strb.recAdd = recAddC;
    strb.recDec = evt.rxOk && (recAddC == '0);
    strb.tecAdd = tecAddC;
    strb.tecDec = evt.txOk && (tecAddC == '0) && !busOff;
    strb.clr    = evt.clr;
  end
endmodule

// File: rtl/can_fc_dpath.sv
module can_fc_dpath
  import can_fc_pkg::*;
#(
  parameter int REC_W       = 8,
  parameter int TEC_W       = 9,
  parameter int PASSIVE_LIM = 127,
  parameter int BUSOFF_LIM  = 255,
  parameter int FOLD_VAL    = 119
) (
  input  logic             clk,
  input  logic             rstN,
  input  strb_t            strb,
  output logic [REC_W-1:0] recQ,
  output logic [TEC_W-1:0] tecQ,
  output logic             errorActive,
  output logic             errorPassive,
  output logic             busOff
);
  localparam logic [REC_W-1:0] REC_MAX  = '1;
  localparam logic [TEC_W-1:0] TEC_MAX  = '1;
  localparam logic [REC_W-1:0] REC_PL   = REC_W'(PASSIVE_LIM);
  localparam logic [TEC_W-1:0] TEC_PL   = TEC_W'(PASSIVE_LIM);
  localparam logic [TEC_W-1:0] TEC_OFF  = TEC_W'(BUSOFF_LIM);
  localparam logic [REC_W-1:0] REC_FOLD = REC_W'(FOLD_VAL);

  logic [REC_W:0] recSum;
  logic [TEC_W:0] tecSum;
  logic [REC_W-1:0] recSat;
  logic [TEC_W-1:0] tecSat;

  assign recSum = {1'b0, recQ} + (REC_W+1)'(strb.recAdd);
  assign tecSum = {1'b0, tecQ} + (TEC_W+1)'(strb.tecAdd);
  assign recSat = recSum[REC_W] ? REC_MAX : recSum[REC_W-1:0];
  assign tecSat = tecSum[TEC_W] ? TEC_MAX : tecSum[TEC_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      recQ <= '0;
    end else if (strb.clr) begin
      recQ <= '0;
    end else if (strb.recAdd != '0) begin
      recQ <= recSat;
    end else if (strb.recDec) begin
      if (recQ > REC_PL)     recQ <= REC_FOLD;
      else if (recQ != '0)   recQ <= recQ - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tecQ <= '0;
    end else if (strb.clr) begin
      tecQ <= '0;
    end else if (strb.tecAdd != '0) begin
      tecQ <= tecSat;
    end else if (strb.tecDec && tecQ != '0) begin
      tecQ <= tecQ - 1'b1;
    end
  end

  assign busOff       = tecQ > TEC_OFF;
  assign errorPassive = !busOff && ((recQ > REC_PL) || (tecQ > TEC_PL));
  assign errorActive  = !busOff && !errorPassive;

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.clr |=> (recQ == '0 && tecQ == '0)); // R11

  AST_REC_FOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.recDec && !strb.clr && recQ > REC_PL) |=> recQ == REC_FOLD); // R5

  AST_TEC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busOff && !strb.clr) |=> tecQ == $past(tecQ)); // R10

  AST_REC_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.recAdd != '0 && !strb.clr) |=> recQ >= $past(recQ)); // R4

  AST_ONE_STATE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot({errorActive, errorPassive, busOff})); // R9
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
  import can_fc_pkg::*;
#(
  parameter int REC_W       = 8,
  parameter int TEC_W       = 9,
  parameter int PASSIVE_LIM = 127,
  parameter int BUSOFF_LIM  = 255,
  parameter int FOLD_VAL    = 119
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             rxErr,
  input  logic             rxBitErrAct,
  input  logic             rxBitErrOvl,
  input  logic             rxDomAfterFlag,
  input  logic             txErrFlag,
  input  logic             txAckPassNoDom,
  input  logic             txArbStuff,
  input  logic             txBitErrFlag,
  input  logic             domPenalty,
  input  logic             isTx,
  input  logic             rxOk,
  input  logic             txOk,
  output logic [REC_W-1:0] rec,
  output logic [TEC_W-1:0] tec,
  output logic             errorActive,
  output logic             errorPassive,
  output logic             busOff
);
  evt_t  evt;
  strb_t strb;

  always_comb begin
    evt.rxErr          = rxErr;
    evt.rxBitErrAct    = rxBitErrAct;
    evt.rxBitErrOvl    = rxBitErrOvl;
    evt.rxDomAfterFlag = rxDomAfterFlag;
    evt.txErrFlag      = txErrFlag;
    evt.txAckPassNoDom = txAckPassNoDom;
    evt.txArbStuff     = txArbStuff;
    evt.txBitErrFlag   = txBitErrFlag;
    evt.domPenalty     = domPenalty;
    evt.isTx           = isTx;
    evt.rxOk           = rxOk;
    evt.txOk           = txOk;
    evt.clr            = clear;
  end

  can_fc_ctrl uCtrl (
    .evt    (evt),
    .busOff (busOff),
    .strb   (strb)
  );

  can_fc_dpath #(
    .REC_W       (REC_W),
    .TEC_W       (TEC_W),
    .PASSIVE_LIM (PASSIVE_LIM),
    .BUSOFF_LIM  (BUSOFF_LIM),
    .FOLD_VAL    (FOLD_VAL)
  ) uDpath (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .recQ         (rec),
    .tecQ         (tec),
    .errorActive  (errorActive),
    .errorPassive (errorPassive),
    .busOff       (busOff)
  );
endmodule

// File: tb/can_fault_conf_test.sv
module can_fault_conf_test;
  import can_fc_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  evt_t cur = '0;
  logic [7:0] rec;
  logic [8:0] tec;
  logic errorActive, errorPassive, busOff;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  int mRec = 0;
  int mTec = 0;

  always #10 clk = ~clk;

  can_fault_conf uut (
    .clk(clk), .rstN(rstN), .clear(cur.clr),
    .rxErr(cur.rxErr), .rxBitErrAct(cur.rxBitErrAct), .rxBitErrOvl(cur.rxBitErrOvl),
    .rxDomAfterFlag(cur.rxDomAfterFlag), .txErrFlag(cur.txErrFlag),
    .txAckPassNoDom(cur.txAckPassNoDom), .txArbStuff(cur.txArbStuff),
    .txBitErrFlag(cur.txBitErrFlag), .domPenalty(cur.domPenalty), .isTx(cur.isTx),
    .rxOk(cur.rxOk), .txOk(cur.txOk),
    .rec(rec), .tec(tec), .errorActive(errorActive), .errorPassive(errorPassive),
    .busOff(busOff)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expState(input int r, input int t);
    if (t > 255) return 1;
    if (r > 127 || t > 127) return 2;
    return 4;
  endfunction

  function automatic int recInc(input evt_t e);
    int a = 0;
    if (e.rxErr) a += e.rxBitErrAct ? 8 : (e.rxBitErrOvl ? 0 : 1);
    if (e.rxDomAfterFlag) a += 8;
    if (e.domPenalty && !e.isTx) a += 8;
    return a;
  endfunction

  function automatic int tecInc(input evt_t e);
    int a = 0;
    if (e.txErrFlag && !e.txAckPassNoDom && !e.txArbStuff) a += 8;
    if (e.txBitErrFlag) a += 8;
    if (e.domPenalty && e.isTx) a += 8;
    return a;
  endfunction

  task automatic modelStep(input evt_t e);
    int ra = recInc(e);
    int ta = tecInc(e);
    bit off = (mTec > 255);
    if (e.clr) begin
      mRec = 0; mTec = 0;
    end else begin
      if (ra > 0) mRec = (mRec + ra > 255) ? 255 : mRec + ra;
      else if (e.rxOk) mRec = (mRec > 127) ? 119 : (mRec > 0 ? mRec - 1 : 0);
      if (!off) begin
        if (ta > 0) mTec = mTec + ta;
        else if (e.txOk && mTec > 0) mTec = mTec - 1;
      end
    end
  endtask

  task automatic step(input evt_t e, input string tag);
    cur = e;
    modelStep(e);
    @(negedge clk);
    cur = '0;
    chk(rec == mRec, {tag, " rec"}, rec, mRec);
    chk(tec == mTec, {tag, " tec"}, tec, mTec);
    chk({errorPassive & 1'b0, errorActive, errorPassive, busOff} == 4'(expState(mRec, mTec)),
        {tag, " state R9"}, int'({errorActive, errorPassive, busOff}), expState(mRec, mTec));
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    evt_t e;
    int unsigned seedV;
    seedV = $urandom(32'h5eed_0042);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rec == 0, "R1 rec after reset", rec, 0);
    chk(tec == 0, "R1 tec after reset", tec, 0);
    chk(errorActive && !errorPassive && !busOff, "R1 flags after reset",
        int'({errorActive, errorPassive, busOff}), 4);

    // R2 receiver error weights
    e = '0; e.rxErr = 1; step(e, "R2 plain rx error");
    chk(rec == 1, "R2 rec is 1", rec, 1);
    e = '0; e.rxErr = 1; e.rxBitErrAct = 1; step(e, "R2 bit err active flag");
    chk(rec == 9, "R2 rec is 9", rec, 9);
    e = '0; e.rxErr = 1; e.rxBitErrOvl = 1; step(e, "R2 bit err overload flag");
    chk(rec == 9, "R2 overload no change", rec, 9);
    // R3 summed receive increments
    e = '0; e.rxDomAfterFlag = 1; e.domPenalty = 1; e.isTx = 0; step(e, "R3 dom after flag + penalty");
    chk(rec == 25, "R3 rec is 25", rec, 25);
    e = '0; e.domPenalty = 1; e.isTx = 1; step(e, "R3 penalty goes to tec when tx");
    chk(rec == 25 && tec == 8, "R3 role select", rec, 25);
    // R5 and R8
    e = '0; e.rxOk = 1; step(e, "R5 rx ok decrement");
    chk(rec == 24, "R5 rec is 24", rec, 24);
    e = '0; e.rxOk = 1; e.rxErr = 1; step(e, "R8 rx ok yields");
    chk(rec == 25, "R8 rec is 25", rec, 25);
    // R4 saturation
    for (int i = 0; i < 30; i++) begin
      e = '0; e.domPenalty = 1; e.rxDomAfterFlag = (i % 2 == 0); step(e, "R4 rec climb");
    end
    chk(rec == 255, "R4 rec saturated", rec, 255);
    chk(errorPassive, "R9 passive from rec", int'(errorPassive), 1);
    e = '0; e.rxOk = 1; step(e, "R5 fold back");
    chk(rec == 119, "R5 rec folded to 119", rec, 119);
    e = '0; e.clr = 1; e.rxErr = 1; e.txErrFlag = 1; step(e, "R11 clear beats events");
    chk(rec == 0 && tec == 0, "R11 both zero", rec + tec, 0);
    e = '0; e.rxOk = 1; step(e, "R5 rx ok at zero");
    chk(rec == 0, "R5 rec stays 0", rec, 0);

    // R6 transmit weights and exemptions
    e = '0; e.txErrFlag = 1; step(e, "R6 tx error flag");
    chk(tec == 8, "R6 tec is 8", tec, 8);
    e = '0; e.txErrFlag = 1; e.txAckPassNoDom = 1; step(e, "R6 ack exemption");
    e = '0; e.txErrFlag = 1; e.txArbStuff = 1; step(e, "R6 arb stuff exemption");
    chk(tec == 8, "R6 exemptions no change", tec, 8);
    e = '0; e.txBitErrFlag = 1; e.txErrFlag = 1; e.domPenalty = 1; e.isTx = 1; step(e, "R6 summed tx");
    chk(tec == 32, "R6 tec is 32", tec, 32);
    e = '0; e.txOk = 1; step(e, "R7 tx ok");
    chk(tec == 31, "R7 tec is 31", tec, 31);
    e = '0; e.txOk = 1; e.txBitErrFlag = 1; step(e, "R8 tx ok yields");
    chk(tec == 39, "R8 tec is 39", tec, 39);
    for (int i = 0; i < 41; i++) begin
      e = '0; e.txOk = 1; step(e, "R7 drain tec");
    end
    chk(tec == 0, "R7 tec stays 0", tec, 0);

    // R9 / R10 bus-off
    for (int i = 0; i < 32; i++) begin
      e = '0; e.txErrFlag = 1; step(e, "R9 tec climb");
    end
    chk(tec == 256 && busOff, "R9 bus-off at 256", tec, 256);
    e = '0; e.txOk = 1; step(e, "R10 tx ok ignored");
    e = '0; e.txErrFlag = 1; e.txBitErrFlag = 1; e.domPenalty = 1; e.isTx = 1; step(e, "R10 tx errors ignored");
    chk(tec == 256, "R10 tec held", tec, 256);
    e = '0; e.clr = 1; step(e, "R11 clear leaves bus-off");
    chk(errorActive && tec == 0, "R11 active after clear", tec, 0);

    // random phases
    for (int i = 0; i < 4000; i++) begin
      int pr = ((i / 500) % 2 == 0) ? 30 : 8;
      int pt = ((i / 500) % 2 == 0) ? 8 : 30;
      e = '0;
      e.rxErr          = ($urandom % 100) < pr;
      e.rxBitErrAct    = ($urandom % 100) < 30;
      e.rxBitErrOvl    = ($urandom % 100) < 30;
      e.rxDomAfterFlag = ($urandom % 100) < pr / 2;
      e.txErrFlag      = ($urandom % 100) < pt;
      e.txAckPassNoDom = ($urandom % 100) < 20;
      e.txArbStuff     = ($urandom % 100) < 20;
      e.txBitErrFlag   = ($urandom % 100) < pt / 3;
      e.domPenalty     = ($urandom % 100) < 10;
      e.isTx           = ($urandom % 2) == 1;
      e.rxOk           = ($urandom % 100) < 40;
      e.txOk           = ($urandom % 100) < 40;
      e.clr            = ($urandom % 1000) < 3;
      step(e, "R2 R3 R4 R5 R6 R7 R8 R10 R11 random");
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule